// File: doc/BRIEF.md
# Random Number Generator Register Front End

This block sits between a host bus and the random word generator of a random number peripheral. The host sees six 32-bit registers on a simple single-cycle request/response bus. Random words pushed in by the generator side wait in an eight-entry output queue, and each host read of the queue register removes one word. The block starts self-test and seed operations on command and records their completion. It also collects error events, including reads of an empty queue, and drives one interrupt line.

The block does not produce entropy and does not run the health tests. Completion and failure of those activities arrive as single-cycle pulses. A read of the empty queue is answered in one of three ways, chosen by a 2-bit control field: plain zeros, a bus error, or zeros together with an interrupt that cannot be masked. Write-only command bits clear the interrupt alone, clear the errors and the interrupt together, or return the whole block to its reset state.

Top module: `rng_regif`

## Requirements
- R1: Registers sit at byte offsets 0x00 identity, 0x04 command, 0x08 control, 0x0C status, 0x10 error, 0x14 queue. The identity register reads {4'b0001, 12'h000, VER_MAJOR, VER_MINOR}. Any other offset reads zero with no bus error.
- R2: The queue holds DEPTH (default 8) words and returns them in arrival order. push_ready is low exactly while the queue is full, and a push offered while full is dropped.
- R3: Status bits 11:8 give the current queue fill level and bits 15:12 give DEPTH (DEPTH must not exceed 15).
- R4: A queue read while the queue is empty sets error bit 4. In underflow modes 2'b00 and 2'b01 (control bits 1:0), that read returns zero and no bus error.
- R5: In underflow mode 2'b10, an empty queue read returns zero with bus_err high. No other access raises bus_err.
- R6: In underflow mode 2'b11, an empty queue read returns zero and drives irq high even when the error mask (control bit 6) is set.
- R7: Writing command bit 4 clears the interrupt and leaves the error register unchanged.
- R8: Writing command bit 5 clears every error bit, status bit 16 and the interrupt.
- R9: Writing command bit 6 returns control, error, interrupt, done flags, pending operations and the queue to their reset state.
- R10: Writing command bit 0 (or bit 1) starts a self test (or seed generation). That command bit reads 1, status bit 1 (busy) is high and selftest_req (or seed_req) is high until the matching done pulse. After the pulse, status bit 4 (or bit 5) stays set until reset. A done pulse with no operation running has no effect.
- R11: st_fail_pulse sets error bit 2 and stat_fail_pulse sets error bit 3. Status bit 16 is high whenever any error bit is set.
- R12: Control reads back bits 1:0 (underflow mode), 4 (auto reseed, also driven on autoreseed_en), 5 (done mask) and 6 (error mask), and reads zero elsewhere. irq is high when a pending done event is unmasked by bit 5 or a pending error event is unmasked by bit 6.
- R13: Writes to the identity, status, error and queue registers are ignored. Command bits 6:4 always read zero.
- R14: A read response (bus_rdata, bus_err) appears on the clock edge that accepts the request and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Bus transfer error, registered |
| push_valid | input | 1 | Generator offers a word |
| push_data | input | 32 | Offered random word |
| push_ready | output | 1 | Queue can accept a word |
| st_done_pulse | input | 1 | Self test finished |
| seed_done_pulse | input | 1 | Seed generation finished |
| st_fail_pulse | input | 1 | Self test failed |
| stat_fail_pulse | input | 1 | Statistical test failed |
| selftest_req | output | 1 | Self test in progress |
| seed_req | output | 1 | Seed generation in progress |
| autoreseed_en | output | 1 | Auto reseed enable |
| irq | output | 1 | Interrupt request |

## Verification
A read response is registered, so it is due on the first rising edge after the request is presented. The bench drives each request on a falling edge and samples the data at the next falling edge. Writes, pushes and event pulses update the status, error, irq and request outputs on the same single edge, so every check reads the result one falling edge after the stimulus is removed and never in the cycle of the stimulus. The queue level is swept from empty past full. Every underflow mode is tried with both states of the error mask.

// File: rtl/rng_regif_pkg.sv
package rng_regif_pkg;

    localparam int OFS_IDENT = 'h00;
    localparam int OFS_CMD   = 'h04;
    localparam int OFS_CTRL  = 'h08;
    localparam int OFS_STAT  = 'h0C;
    localparam int OFS_ERR   = 'h10;
    localparam int OFS_QUEUE = 'h14;

    localparam int CMD_SELFTEST = 0;
    localparam int CMD_SEED     = 1;
    localparam int CMD_CLR_IRQ  = 4;
    localparam int CMD_CLR_ERR  = 5;
    localparam int CMD_SOFT_RST = 6;

    localparam logic [3:0] GEN_TYPE = 4'b0001;

    typedef enum logic [1:0] {
        UF_ZERO_A = 2'b00,
        UF_ZERO_B = 2'b01,
        UF_BUSERR = 2'b10,
        UF_FORCE  = 2'b11
    } uf_mode_e;

    typedef struct packed {
        uf_mode_e    uf_mode;
        logic        auto_reseed;
        logic        mask_done;
        logic        mask_err;
        logic        err_st;
        logic        err_stat;
        logic        err_uf;
        logic        pend_done;
        logic        pend_err;
        logic        pend_force;
        logic [31:0] rsp_data;
        logic        rsp_err;
    } regs_t;

    localparam regs_t REGS_RST = '{
        uf_mode:     UF_ZERO_A,
        auto_reseed: 1'b0,
        mask_done:   1'b0,
        mask_err:    1'b0,
        err_st:      1'b0,
        err_stat:    1'b0,
        err_uf:      1'b0,
        pend_done:   1'b0,
        pend_err:    1'b0,
        pend_force:  1'b0,
        rsp_data:    32'h0,
        rsp_err:     1'b0
    };

endpackage

// File: rtl/rng_out_fifo.sv
module rng_out_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          push,
    input  logic [DATA_W-1:0]             push_data,
    input  logic                          pop,
    output logic                          full,
    output logic                          empty,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic [DATA_W-1:0]             head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    logic do_push, do_pop;

    assign full  = (ptr_q.lvl == LVL_W'(DEPTH));
    assign empty = (ptr_q.lvl == '0);
    assign level = ptr_q.lvl;
    assign head  = mem_q[ptr_q.rd];

    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;

    always_comb begin
        ptr_d = ptr_q;
        mem_d = mem_q;
        if (do_push) begin
            mem_d[ptr_q.wr] = push_data;
            ptr_d.wr = (ptr_q.wr == LAST) ? '0 : ptr_q.wr + 1'b1;
        end
        if (do_pop) begin
            ptr_d.rd = (ptr_q.rd == LAST) ? '0 : ptr_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   ptr_d.lvl = ptr_q.lvl + 1'b1;
            2'b01:   ptr_d.lvl = ptr_q.lvl - 1'b1;
            default: ptr_d.lvl = ptr_q.lvl;
        endcase
        if (clear) begin
            ptr_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/rng_op_tracker.sv
module rng_op_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    input  logic done_in,
    output logic active,
    output logic done_flag,
    output logic finish
);
    typedef struct packed {
        logic active;
        logic done;
    } op_t;

    op_t op_d, op_q;

    assign active    = op_q.active;
    assign done_flag = op_q.done;
    assign finish    = done_in & op_q.active;

    always_comb begin
        op_d = op_q;
        if (finish) begin
            op_d.active = 1'b0;
            op_d.done   = 1'b1;
        end else if (start) begin
            op_d.active = 1'b1;
        end
        if (clear) begin
            op_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0;
        end else begin
            op_q <= op_d;
        end
    end

endmodule

// File: rtl/rng_regif.sv
module rng_regif
    import rng_regif_pkg::*;
#(
    parameter int         DEPTH     = 8,
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] VER_MAJOR = 8'h02,
    parameter logic [7:0] VER_MINOR = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              push_valid,
    input  logic [31:0]       push_data,
    output logic              push_ready,
    input  logic              st_done_pulse,
    input  logic              seed_done_pulse,
    input  logic              st_fail_pulse,
    input  logic              stat_fail_pulse,
    output logic              selftest_req,
    output logic              seed_req,
    output logic              autoreseed_en,
    output logic              irq
);
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int N_OPS  = 2;

    regs_t r_d, r_q;

    logic              rd_req, wr_req;
    logic              sel_cmd, sel_ctrl, sel_queue;
    logic              soft_rst, clr_irq, clr_err;
    logic              q_pop, q_underflow;
    logic              q_full, q_empty;
    logic [LVL_W-1:0]  fifo_level;
    logic [31:0]       q_head;
    logic [31:0]       rd_mux;
    logic [31:0]       stat_word;
    logic              any_err;
    logic [1:0]        ctl_mode;

    logic [N_OPS-1:0]  op_start, op_done_in, op_active, op_done, op_finish;

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[31:7], bus_wdata[3:2]};

    assign rd_req    = bus_sel & ~bus_we;
    assign wr_req    = bus_sel &  bus_we;
    assign sel_cmd   = (bus_addr == ADDR_W'(OFS_CMD));
    assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_queue = (bus_addr == ADDR_W'(OFS_QUEUE));

    assign soft_rst = wr_req & sel_cmd & bus_wdata[CMD_SOFT_RST];
    assign clr_irq  = wr_req & sel_cmd & bus_wdata[CMD_CLR_IRQ];
    assign clr_err  = wr_req & sel_cmd & bus_wdata[CMD_CLR_ERR];

    assign q_pop       = rd_req & sel_queue & ~q_empty;
    assign q_underflow = rd_req & sel_queue &  q_empty;

    assign op_start[0]   = wr_req & sel_cmd & bus_wdata[CMD_SELFTEST] & ~soft_rst;
    assign op_start[1]   = wr_req & sel_cmd & bus_wdata[CMD_SEED] & ~soft_rst;
    assign op_done_in[0] = st_done_pulse;
    assign op_done_in[1] = seed_done_pulse;

    rng_out_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (32)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (soft_rst),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (q_pop),
        .full      (q_full),
        .empty     (q_empty),
        .level     (fifo_level),
        .head      (q_head)
    );

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        rng_op_tracker u_op (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (soft_rst),
            .start     (op_start[g]),
            .done_in   (op_done_in[g]),
            .active    (op_active[g]),
            .done_flag (op_done[g]),
            .finish    (op_finish[g])
        );
    end

    assign any_err  = r_q.err_st | r_q.err_stat | r_q.err_uf;
    assign ctl_mode = r_q.uf_mode;

    always_comb begin
        stat_word        = '0;
        stat_word[1]     = |op_active;
        stat_word[4]     = op_done[0];
        stat_word[5]     = op_done[1];
        stat_word[11:8]  = 4'(fifo_level);
        stat_word[15:12] = 4'(DEPTH);
        stat_word[16]    = any_err;
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFS_IDENT): rd_mux = {GEN_TYPE, 12'h000, VER_MAJOR, VER_MINOR};
            ADDR_W'(OFS_CMD):   rd_mux = {30'h0, op_active[1], op_active[0]};
            ADDR_W'(OFS_CTRL):  rd_mux = {25'h0, r_q.mask_err, r_q.mask_done,
                                          r_q.auto_reseed, 2'b00, r_q.uf_mode};
            ADDR_W'(OFS_STAT):  rd_mux = stat_word;
            ADDR_W'(OFS_ERR):   rd_mux = {27'h0, r_q.err_uf, r_q.err_stat,
                                          r_q.err_st, 2'b00};
            ADDR_W'(OFS_QUEUE): rd_mux = q_empty ? 32'h0 : q_head;
            default:            rd_mux = '0;
        endcase
    end

    always_comb begin
        r_d          = r_q;
        r_d.rsp_err  = 1'b0;
        r_d.rsp_data = rd_req ? rd_mux : 32'h0;

        if (wr_req && sel_ctrl) begin
            r_d.uf_mode     = uf_mode_e'(bus_wdata[1:0]);
            r_d.auto_reseed = bus_wdata[4];
            r_d.mask_done   = bus_wdata[5];
            r_d.mask_err    = bus_wdata[6];
        end

        if (clr_irq || clr_err) begin
            r_d.pend_done  = 1'b0;
            r_d.pend_err   = 1'b0;
            r_d.pend_force = 1'b0;
        end
        if (clr_err) begin
            r_d.err_st   = 1'b0;
            r_d.err_stat = 1'b0;
            r_d.err_uf   = 1'b0;
        end

        if (st_fail_pulse) begin
            r_d.err_st   = 1'b1;
            r_d.pend_err = 1'b1;
        end
        if (stat_fail_pulse) begin
            r_d.err_stat = 1'b1;
            r_d.pend_err = 1'b1;
        end
        if (q_underflow) begin
            r_d.err_uf   = 1'b1;
            r_d.pend_err = 1'b1;
            r_d.rsp_data = 32'h0;
            if (r_q.uf_mode == UF_BUSERR) begin
                r_d.rsp_err = 1'b1;
            end
            if (r_q.uf_mode == UF_FORCE) begin
                r_d.pend_force = 1'b1;
            end
        end
        if (|op_finish) begin
            r_d.pend_done = 1'b1;
        end

        if (soft_rst) begin
            r_d = REGS_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata     = r_q.rsp_data;
    assign bus_err       = r_q.rsp_err;
    assign push_ready    = ~q_full;
    assign selftest_req  = op_active[0];
    assign seed_req      = op_active[1];
    assign autoreseed_en = r_q.auto_reseed;
    assign irq           = (r_q.pend_done & ~r_q.mask_done)
                         | (r_q.pend_err  & ~r_q.mask_err)
                         |  r_q.pend_force;

endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk
    import rng_regif_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [31:0]                bus_wdata,
    input logic [31:0]                bus_rdata,
    input logic                       bus_err,
    input logic                       push_ready,
    input logic                       irq,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level,
    input logic [1:0]                 ctl_mode
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic rd_queue, rd_cmd, rd_ident, wr_srst;
    assign rd_queue = bus_sel & ~bus_we & (bus_addr == ADDR_W'(OFS_QUEUE));
    assign rd_cmd   = bus_sel & ~bus_we & (bus_addr == ADDR_W'(OFS_CMD));
    assign rd_ident = bus_sel & ~bus_we & (bus_addr == ADDR_W'(OFS_IDENT));
    assign wr_srst  = bus_sel &  bus_we & (bus_addr == ADDR_W'(OFS_CMD))
                    & bus_wdata[CMD_SOFT_RST];

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    assert_full_blocks_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == LVL_W'(DEPTH)) |-> !push_ready);

    assert_err_only_queue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !rd_queue) |=> !bus_err);

    assert_err_needs_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($past(ctl_mode) == 2'b10));

    assert_forced_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_queue && fifo_level == '0 && ctl_mode == 2'b11) |=> irq);

    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_srst |=> (fifo_level == '0 && push_ready && !irq && ctl_mode == 2'b00));

    assert_cmd_wo_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> (bus_rdata[6:4] == 3'b000));

    assert_ident_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ident |=> (bus_rdata[31:28] == GEN_TYPE));

endmodule

bind rng_regif rng_regif_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .push_ready (push_ready),
    .irq        (irq),
    .fifo_level (fifo_level),
    .ctl_mode   (ctl_mode)
);

// File: tb/tb_rng_regif.sv
`timescale 1ns/1ps
module tb_rng_regif;
    localparam int         DEPTH = 8;
    localparam logic [7:0] MAJ   = 8'h02;
    localparam logic [7:0] MIN   = 8'h05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic        push_ready;
    logic        st_done_pulse = 1'b0, seed_done_pulse = 1'b0;
    logic        st_fail_pulse = 1'b0, stat_fail_pulse = 1'b0;
    logic        selftest_req, seed_req, autoreseed_en, irq;

    int nvec = 0;
    int nbad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rng_regif #(.DEPTH(DEPTH), .ADDR_W(8), .VER_MAJOR(MAJ), .VER_MINOR(MIN)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .st_done_pulse(st_done_pulse), .seed_done_pulse(seed_done_pulse),
        .st_fail_pulse(st_fail_pulse), .stat_fail_pulse(stat_fail_pulse),
        .selftest_req(selftest_req), .seed_req(seed_req),
        .autoreseed_en(autoreseed_en), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; e = bus_err;
        bus_sel = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] d, output logic taken);
        @(negedge clk);
        push_valid = 1'b1; push_data = d; taken = push_ready;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: st_done_pulse = 1'b1;
            1: seed_done_pulse = 1'b1;
            2: st_fail_pulse = 1'b1;
            default: stat_fail_pulse = 1'b1;
        endcase
        @(negedge clk);
        st_done_pulse = 1'b0; seed_done_pulse = 1'b0;
        st_fail_pulse = 1'b0; stat_fail_pulse = 1'b0;
    endtask

    function automatic logic [31:0] exp_stat(int lvl, bit sdn, bit stdn, bit busy, bit err);
        return (32'(err) << 16) | (32'(DEPTH) << 12) | (32'(lvl) << 8)
             | (32'(sdn) << 5) | (32'(stdn) << 4) | (32'(busy) << 1);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL R14 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic        e;
        logic        taken;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R1, R3, R12)
        bus_rd(8'h00, d, e); check("R1 ident", d, {4'b0001, 12'h0, MAJ, MIN});
        bus_rd(8'h04, d, e); check("R10 cmd reset", d, 0);
        bus_rd(8'h08, d, e); check("R12 ctrl reset", d, 0);
        bus_rd(8'h0C, d, e); check("R3 status reset", d, exp_stat(0, 0, 0, 0, 0));
        bus_rd(8'h10, d, e); check("R11 err reset", d, 0);
        check("R12 irq reset", 32'(irq), 0);
        check("R2 ready reset", 32'(push_ready), 1);
        for (int a = 8'h18; a < 8'h40; a += 4) begin
            bus_rd(8'(a), d, e);
            check("R1 unmapped data", d, 0);
            check("R5 unmapped err", 32'(e), 0);
        end

        // Read-only registers ignore writes (R13)
        bus_wr(8'h00, 32'hFFFF_FFFF); bus_rd(8'h00, d, e);
        check("R13 ident wr", d, {4'b0001, 12'h0, MAJ, MIN});
        bus_wr(8'h0C, 32'hFFFF_FFFF); bus_rd(8'h0C, d, e);
        check("R13 status wr", d, exp_stat(0, 0, 0, 0, 0));
        bus_wr(8'h10, 32'hFFFF_FFFF); bus_rd(8'h10, d, e);
        check("R13 err wr", d, 0);
        bus_wr(8'h14, 32'hFFFF_FFFF); bus_rd(8'h0C, d, e);
        check("R13 queue wr", d, exp_stat(0, 0, 0, 0, 0));
        bus_wr(8'h04, 32'h30); bus_rd(8'h04, d, e);
        check("R13 cmd wo bits", d, 0);

        // Control readback sweep (R12)
        for (int v = 0; v < 128; v++) begin
            bus_wr(8'h08, 32'(v));
            bus_rd(8'h08, d, e);
            check("R12 ctrl readback", d, 32'(v) & 32'h73);
            check("R12 autoreseed out", 32'(autoreseed_en), 32'((v >> 4) & 1));
        end
        bus_wr(8'h08, 0);

        // Fill sweep past full (R2, R3)
        for (int k = 0; k < DEPTH + 2; k++) begin
            push_word(32'hA500_0000 + 32'(k * 32'h0101), taken);
            check("R2 push accepted", 32'(taken), 32'(k < DEPTH));
            bus_rd(8'h0C, d, e);
            check("R3 level filling", d, exp_stat((k + 1 > DEPTH) ? DEPTH : k + 1, 0, 0, 0, 0));
            check("R2 ready vs full", 32'(push_ready), 32'(k + 1 < DEPTH));
        end
        for (int k = 0; k < DEPTH; k++) begin
            bus_rd(8'h14, d, e);
            check("R2 order", d, 32'hA500_0000 + 32'(k * 32'h0101));
            check("R14 pop no err", 32'(e), 0);
            bus_rd(8'h0C, d, e);
            check("R3 level draining", d, exp_stat(DEPTH - 1 - k, 0, 0, 0, 0));
        end

        // Underflow sweep over mode and error mask (R4, R5, R6, R7, R8)
        for (int m = 0; m < 4; m++) begin
            for (int mk = 0; mk < 2; mk++) begin
                bus_wr(8'h04, 32'h20);
                bus_wr(8'h08, 32'(m) | (32'(mk) << 6));
                bus_rd(8'h14, d, e);
                check("R4 underflow data", d, 0);
                check("R5 underflow err", 32'(e), 32'(m == 2));
                check("R6 underflow irq", 32'(irq), 32'((m == 3) || (mk == 0)));
                bus_rd(8'h10, d, e);
                check("R4 underflow flag", d, 32'h10);
                bus_rd(8'h0C, d, e);
                check("R11 status err", d, exp_stat(0, 0, 0, 0, 1));
                bus_wr(8'h04, 32'h10);
                check("R7 irq cleared", 32'(irq), 0);
                bus_rd(8'h10, d, e);
                check("R7 err kept", d, 32'h10);
                bus_wr(8'h04, 32'h20);
                bus_rd(8'h10, d, e);
                check("R8 err cleared", d, 0);
                bus_rd(8'h0C, d, e);
                check("R8 status err clear", d, exp_stat(0, 0, 0, 0, 0));
            end
        end
        bus_wr(8'h08, 0);

        // Self test and seed operations (R10, R12)
        bus_wr(8'h04, 32'h1);
        bus_rd(8'h04, d, e); check("R10 cmd st pending", d, 1);
        bus_rd(8'h0C, d, e); check("R10 busy", d, exp_stat(0, 0, 0, 1, 0));
        check("R10 selftest_req", 32'(selftest_req), 1);
        pulse(1);
        bus_rd(8'h0C, d, e); check("R10 idle seed pulse ignored", d, exp_stat(0, 0, 0, 1, 0));
        check("R12 no irq yet", 32'(irq), 0);
        pulse(0);
        bus_rd(8'h0C, d, e); check("R10 st done", d, exp_stat(0, 0, 1, 0, 0));
        check("R10 selftest_req low", 32'(selftest_req), 0);
        check("R12 done irq", 32'(irq), 1);
        bus_wr(8'h04, 32'h10);
        check("R7 done irq cleared", 32'(irq), 0);
        bus_rd(8'h0C, d, e); check("R10 st done sticky", d, exp_stat(0, 0, 1, 0, 0));
        bus_wr(8'h08, 32'h20);
        bus_wr(8'h04, 32'h2);
        check("R10 seed_req", 32'(seed_req), 1);
        bus_rd(8'h04, d, e); check("R10 cmd seed pending", d, 2);
        pulse(1);
        bus_rd(8'h0C, d, e); check("R10 seed done", d, exp_stat(0, 1, 1, 0, 0));
        check("R12 done masked", 32'(irq), 0);
        bus_wr(8'h08, 0);
        check("R12 done unmasked", 32'(irq), 1);
        bus_wr(8'h04, 32'h10);

        // Fail pulses (R11, R12, R8)
        pulse(2);
        bus_rd(8'h10, d, e); check("R11 st fail", d, 32'h4);
        pulse(3);
        bus_rd(8'h10, d, e); check("R11 stat fail", d, 32'hC);
        bus_rd(8'h0C, d, e); check("R11 status err", d, exp_stat(0, 1, 1, 0, 1));
        check("R12 err irq", 32'(irq), 1);
        bus_wr(8'h08, 32'h40);
        check("R12 err masked", 32'(irq), 0);
        bus_wr(8'h08, 0);
        bus_wr(8'h04, 32'h20);
        bus_rd(8'h10, d, e); check("R8 clear fails", d, 0);
        check("R8 irq clear", 32'(irq), 0);

        // Soft reset (R9)
        for (int k = 0; k < 3; k++) push_word(32'h1234_0000 + 32'(k), taken);
        bus_wr(8'h08, 32'h53);
        bus_wr(8'h04, 32'h1);
        pulse(2);
        bus_wr(8'h04, 32'h40);
        bus_rd(8'h08, d, e); check("R9 ctrl reset", d, 0);
        bus_rd(8'h0C, d, e); check("R9 status reset", d, exp_stat(0, 0, 0, 0, 0));
        bus_rd(8'h10, d, e); check("R9 err reset", d, 0);
        bus_rd(8'h04, d, e); check("R9 op cancelled", d, 0);
        check("R9 irq low", 32'(irq), 0);
        check("R9 selftest_req low", 32'(selftest_req), 0);
        push_word(32'hBEEF_0001, taken);
        bus_rd(8'h14, d, e); check("R9 queue emptied", d, 32'hBEEF_0001);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule